// File: doc/BRIEF.md
# Boundary Scan Cell Chain

A chain of identical scan cells. Each cell sits on one signal crossing between a device pin and the core logic. In functional operation a cell passes its parallel input straight to its parallel output. When test mode is selected, the cell instead drives the value held in its update stage, so the core can be cut off from a pin, or a pin from the core, and a chosen value applied to either.

Every cell has two stages. The first is a capture/shift flop. It samples the parallel input on a capture strobe, or takes the serial output of the preceding cell on a shift strobe. The cells are linked from the serial input toward the serial output to form one shift register, with one bit per cell. The second is an update flop. It copies the capture/shift stage on an update strobe, so the driven values do not ripple while new data is shifted in.

All strobes come from an external test access port controller. They are sampled on the rising edge of the test clock. The serial output feeds a data-register select multiplexer outside this block.

Top module: `bsr_chain`

## Requirements
- R1: While rst_ni is low, every capture/shift and update stage is 0, so tdo_o is 0 and, with test_mode_i high, par_out_o is all zeros.
- R2: With test_mode_i low, par_out_o equals par_in_i bit for bit, combinationally.
- R3: With test_mode_i high, par_out_o equals the update stages and does not follow changes on par_in_i.
- R4: A rising clock edge with capture_i high loads par_in_i[k] into cell k. tdo_o then shows the value captured in cell N_CELLS-1.
- R5: A rising clock edge with shift_i high and capture_i low moves each cell's bit to the next higher-numbered cell. tdi_i enters cell 0. tdo_o shows cell N_CELLS-1, so captured bits leave highest index first.
- R6: When capture_i and shift_i are both high, the capture takes priority.
- R7: A rising clock edge with update_i high copies every capture/shift stage into its update stage. Without update_i, the update stages hold, even while shifting.
- R8: With capture_i and shift_i both low, the capture/shift stages and tdo_o hold.
- R9: A bit presented on tdi_i appears on tdo_o after exactly N_CELLS shift edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| test_mode_i | input | 1 | Selects held values onto the parallel outputs |
| tdi_i | input | 1 | Serial scan input |
| par_in_i | input | N_CELLS | Parallel inputs, one per cell |
| par_out_o | output | N_CELLS | Parallel outputs, one per cell |
| tdo_o | output | 1 | Serial scan output (last cell) |

## Verification
The bench builds the chain with N_CELLS = 5. This length is odd and not a power of two, so an off-by-one in the serial link or in the tdo timing shows up as a wrong bit on a known edge, and a full unload stays short. Five cells also let random strobe mixes reach every overlap of capture, shift and update within a few hundred cycles. Directed steps fix the exit order, the five-edge latency and the capture-over-shift priority.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2
  } scan_op_e;
endpackage

// File: rtl/bsr_strobe.sv
module bsr_strobe
  import bsr_pkg::*;
(
  input  logic     capture_i,
  input  logic     shift_i,
  output scan_op_e op_o
);
  // capture wins over shift
  always_comb begin
    if (capture_i)    op_o = OP_CAPTURE;
    else if (shift_i) op_o = OP_SHIFT;
    else              op_o = OP_HOLD;
  end
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
  import bsr_pkg::*;
(
  input  logic     tck_i,
  input  logic     rst_ni,
  input  scan_op_e op_i,
  input  logic     update_i,
  input  logic     test_mode_i,
  input  logic     par_i,
  input  logic     si_i,
  output logic     so_o,
  output logic     par_o
);
  logic cap_q, upd_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else begin
      case (op_i)
        OP_CAPTURE: cap_q <= par_i;
        OP_SHIFT:   cap_q <= si_i;
        default:    cap_q <= cap_q;
      endcase
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       upd_q <= 1'b0;
    else if (update_i) upd_q <= cap_q;
  end

  assign so_o  = cap_q;
  assign par_o = test_mode_i ? upd_q : par_i;

  // R4
  capture_load_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    op_i == OP_CAPTURE |=> so_o == $past(par_i));
  // R5
  shift_load_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    op_i == OP_SHIFT |=> so_o == $past(si_i));
  // R8
  hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    op_i == OP_HOLD |=> $stable(so_o));
  // R7
  update_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(upd_q));
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               test_mode_i,
  input  logic               tdi_i,
  input  logic [N_CELLS-1:0] par_in_i,
  output logic [N_CELLS-1:0] par_out_o,
  output logic               tdo_o
);
  localparam int unsigned LAST = N_CELLS - 1;

  scan_op_e           op;
  logic [N_CELLS:0]   link;

  bsr_strobe u_strobe (
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .op_o      (op)
  );

  assign link[0] = tdi_i;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    bsr_cell u_cell (
      .tck_i       (tck_i),
      .rst_ni      (rst_ni),
      .op_i        (op),
      .update_i    (update_i),
      .test_mode_i (test_mode_i),
      .par_i       (par_in_i[k]),
      .si_i        (link[k]),
      .so_o        (link[k+1]),
      .par_o       (par_out_o[k])
    );
  end

  assign tdo_o = link[N_CELLS];

  // R6
  capture_priority_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i && shift_i |=> tdo_o == $past(par_in_i[LAST]));
  // R3
  held_output_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    test_mode_i && $past(test_mode_i) && !$past(update_i) |-> $stable(par_out_o));
endmodule

// File: tb/bsr_chain_test.sv
module bsr_chain_test;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         capture = 1'b0, shift = 1'b0, update = 1'b0;
  logic         mode = 1'b0, tdi = 1'b0;
  logic [N-1:0] par_in = '0;
  logic [N-1:0] par_out;
  logic         tdo;

  int n_run = 0, n_fail = 0;
  logic [N-1:0] m_cap = '0, m_upd = '0;

  always #10ns clk = ~clk;

  bsr_chain #(.N_CELLS(N)) uut (
    .tck_i(clk), .rst_ni(rst_n), .capture_i(capture), .shift_i(shift),
    .update_i(update), .test_mode_i(mode), .tdi_i(tdi),
    .par_in_i(par_in), .par_out_o(par_out), .tdo_o(tdo)
  );

  function automatic logic [N-1:0] next_cap(input logic [N-1:0] cur, input logic c,
                                            input logic s, input logic d, input logic [N-1:0] p);
    if (c) return p;
    if (s) return (cur << 1) | N'(d);
    return cur;
  endfunction

  function automatic logic [N-1:0] exp_out(input logic m, input logic [N-1:0] u,
                                           input logic [N-1:0] p);
    return m ? u : p;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R5 tdo"}, N'(tdo), N'(m_cap[N-1]));
    chk({tag, " R3 par_out"}, par_out, exp_out(mode, m_upd, par_in));
  endtask

  // drive after negedge, model on posedge, check at next negedge
  task automatic cycle(input string tag, input logic c, input logic s, input logic u,
                       input logic d, input logic m, input logic [N-1:0] p);
    capture = c; shift = s; update = u; tdi = d; mode = m; par_in = p;
    @(posedge clk);
    if (u) m_upd = m_cap;
    m_cap = next_cap(m_cap, c, s, d, p);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(20ns * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    void'($urandom(32'd2024));
    // R1: reset state
    mode = 1'b1; par_in = 5'b10101;
    @(negedge clk);
    chk("R1 tdo in reset", N'(tdo), '0);
    chk("R1 par_out in reset", par_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: pass-through
    mode = 1'b0;
    for (int i = 0; i < 4; i++) begin
      par_in = N'($urandom);
      #2ns;
      chk("R2 pass-through", par_out, par_in);
    end
    // R4: capture then R5 unload order
    cycle("R4 capture", 1, 0, 0, 0, 0, 5'b10110);
    chk("R4 tdo after capture", N'(tdo), N'(1'b1));
    for (int i = 0; i < N - 1; i++) cycle("R5 unload", 0, 1, 0, 0, 0, '0);
    // R9: single one walks through
    cycle("R9 inject", 0, 1, 0, 1, 0, '0);
    for (int i = 1; i < N; i++) begin
      chk("R9 early", N'(tdo), '0);
      cycle("R9 walk", 0, 1, 0, 0, 0, '0);
    end
    chk("R9 arrival", N'(tdo), N'(1'b1));
    // R6: capture beats shift
    cycle("R6 both", 1, 1, 0, 0, 0, '1);
    chk("R6 captured", N'(tdo), N'(1'b1));
    // R7: update then shift in test mode
    cycle("R7 load", 1, 0, 0, 0, 1, 5'b01101);
    cycle("R7 update", 0, 0, 1, 0, 1, 5'b00000);
    held = par_out;
    chk("R7 update value", held, 5'b01101);
    for (int i = 0; i < N; i++) cycle("R7 shift", 0, 1, 0, i[0], 1, N'($urandom));
    chk("R7 no ripple", par_out, held);
    // R3: par_in ignored in test mode
    for (int i = 0; i < 3; i++) begin
      par_in = N'($urandom);
      #2ns;
      chk("R3 isolated", par_out, held);
    end
    // R8: hold
    cycle("R8 idle", 0, 0, 0, 1, 0, '1);
    held = N'(tdo);
    for (int i = 0; i < 3; i++) begin
      cycle("R8 idle", 0, 0, 0, 1, 0, N'($urandom));
      chk("R8 tdo held", N'(tdo), held);
    end
    // random mix
    begin
      logic m = 1'b0;
      for (int i = 0; i < 400; i++) begin
        if (i % 16 == 0) m = 1'($urandom);
        cycle("rand", ($urandom % 4) == 0, 1'($urandom), ($urandom % 5) == 0,
              1'($urandom), m, N'($urandom));
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule